// File: doc/BRIEF.md
# Display Address Mapping Counter

This block produces the lookup addresses for two small mapping memories that remap video memory addresses while the screen is refreshed. A row index advances on every display clock and returns to zero while blanking is active. A column index advances once for each blanking interval and returns to zero on vertical sync. The two indices address a row mapping RAM and a column mapping RAM. The bytes those RAMs return are captured and sent out as one video memory address, row half first and column half second, with a select output that marks the half on the bus.

A host can write either mapping RAM through a select, chip-select and write-strobe port. The graphics controller can read the RAMs with its data-in strobe together with the same select. During either kind of access the RAM address buses follow the host address, and the counters and the captured mapping data stay as they are. The RAM arrays sit outside the block.

Top module: `vmap_counter`

## Requirements
- R1: While rst_n is low, both RAM address outputs, vaddr_o and vaddr_col_o read 0, provided no host access is present.
- R2: With no host access and blank_i low, the row index goes up by one on each clk edge and wraps from 2^ROW_AW-1 to 0.
- R3: With no host access, a clk edge that sees blank_i high sets the row index to 0.
- R4: With no host access, the column index goes up by one on the first clk edge that sees blank_i high after it was low, and wraps from 2^COL_AW-1 to 0.
- R5: With no host access, a clk edge that sees vsync_i high sets the column index to 0, even when a blanking rise is seen at the same edge.
- R6: A host access is a write (map_sel_i, cs_i and wr_i all high) or a controller read (map_sel_i and gc_rd_i high). During one, row_map_addr_o carries host_addr_i[ROW_AW-1:0], col_map_addr_o carries host_addr_i[COL_AW-1:0] and map_buf_en_o is high; otherwise the addresses are the indices and map_buf_en_o is low.
- R7: During a write, row_map_we_o is high when host_addr_i[HOST_AW-1] is 0 and col_map_we_o is high when it is 1; map_wdata_o always equals host_data_i. A controller read raises no write enable.
- R8: During a host access both indices hold their values, and blank_i and vsync_i have no effect on them.
- R9: vaddr_col_o toggles on every clk edge after reset. At an edge where it was 1 and no host access is present, both RAM data inputs are captured; vaddr_o shows the captured row byte while vaddr_col_o is 0 and the captured column byte while it is 1.
- R10: At an edge where a host access is present, the captured mapping bytes are not replaced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Display clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| blank_i | input | 1 | Blanking level from the display controller |
| vsync_i | input | 1 | Vertical sync level |
| map_sel_i | input | 1 | Selects the mapping RAM path for host or controller access |
| cs_i | input | 1 | Host chip select |
| wr_i | input | 1 | Host write strobe |
| gc_rd_i | input | 1 | Graphics controller data-in strobe |
| host_addr_i | input | HOST_AW | Host address |
| host_data_i | input | DW | Host write data |
| row_map_q_i | input | DW | Data returned by the row mapping RAM |
| col_map_q_i | input | DW | Data returned by the column mapping RAM |
| row_map_addr_o | output | ROW_AW | Row mapping RAM address |
| col_map_addr_o | output | COL_AW | Column mapping RAM address |
| row_map_we_o | output | 1 | Row mapping RAM write enable |
| col_map_we_o | output | 1 | Column mapping RAM write enable |
| map_wdata_o | output | DW | Write data to the mapping RAMs |
| map_buf_en_o | output | 1 | Data bus buffer gate for the mapping RAMs |
| vaddr_o | output | DW | Multiplexed video memory address half |
| vaddr_col_o | output | 1 | 1 while vaddr_o carries the column half |

## Verification
The bench keeps the default widths: a 7-bit row index, a 10-bit column index, a 16-bit host address and 8-bit data. With a 128-entry row space, the row wrap appears after a short run without blanking. With a 1024-entry column space, about a thousand short blanking pulses reach the column wrap well inside the cycle budget. Bit 15 of the host address picks the RAM that a write goes to, so one write sequence covers both write enables.

// File: rtl/vmap_counter.sv
module vmap_counter #(
  parameter int ROW_AW  = 7,
  parameter int COL_AW  = 10,
  parameter int HOST_AW = 16,
  parameter int DW      = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               blank_i,
  input  logic               vsync_i,
  input  logic               map_sel_i,
  input  logic               cs_i,
  input  logic               wr_i,
  input  logic               gc_rd_i,
  input  logic [HOST_AW-1:0] host_addr_i,
  input  logic [DW-1:0]      host_data_i,
  input  logic [DW-1:0]      row_map_q_i,
  input  logic [DW-1:0]      col_map_q_i,
  output logic [ROW_AW-1:0]  row_map_addr_o,
  output logic [COL_AW-1:0]  col_map_addr_o,
  output logic               row_map_we_o,
  output logic               col_map_we_o,
  output logic [DW-1:0]      map_wdata_o,
  output logic               map_buf_en_o,
  output logic [DW-1:0]      vaddr_o,
  output logic               vaddr_col_o
);

  localparam int RAM_SEL_BIT = HOST_AW - 1;

  logic              host_wr;
  logic              host_acc;
  logic              blank_q;
  logic              blank_rise;
  logic              half_col;
  logic [ROW_AW-1:0] row_cnt;
  logic [COL_AW-1:0] col_cnt;
  logic [DW-1:0]     cap_row;
  logic [DW-1:0]     cap_col;

  assign host_wr    = map_sel_i & cs_i & wr_i;
  assign host_acc   = host_wr | (map_sel_i & gc_rd_i);
  assign blank_rise = blank_i & ~blank_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      row_cnt <= '0;
    else if (!host_acc)
      row_cnt <= blank_i ? '0 : row_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      col_cnt <= '0;
    else if (!host_acc) begin
      if (vsync_i)
        col_cnt <= '0;
      else if (blank_rise)
        col_cnt <= col_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blank_q  <= 1'b0;
      half_col <= 1'b0;
    end else begin
      blank_q  <= blank_i;
      half_col <= ~half_col;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_row <= '0;
      cap_col <= '0;
    end else if (half_col && !host_acc) begin
      cap_row <= row_map_q_i;
      cap_col <= col_map_q_i;
    end
  end

  assign row_map_addr_o = host_acc ? host_addr_i[ROW_AW-1:0] : row_cnt;
  assign col_map_addr_o = host_acc ? host_addr_i[COL_AW-1:0] : col_cnt;
  assign row_map_we_o   = host_wr & ~host_addr_i[RAM_SEL_BIT];
  assign col_map_we_o   = host_wr &  host_addr_i[RAM_SEL_BIT];
  assign map_wdata_o    = host_data_i;
  assign map_buf_en_o   = host_acc;
  assign vaddr_o        = half_col ? cap_col : cap_row;
  assign vaddr_col_o    = half_col;

endmodule

module vmap_counter_chk #(
  parameter int RW = 7,
  parameter int CW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          acc,
  input logic          blank_i,
  input logic          vsync_i,
  input logic [RW-1:0] row_cnt,
  input logic [CW-1:0] col_cnt,
  input logic          half_col,
  input logic          buf_en,
  input logic          row_we,
  input logic          col_we
);

  logic [RW-1:0] row_next;
  assign row_next = row_cnt + 1'b1;

  // R2
  row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc && !blank_i) |=> row_cnt == $past(row_next));

  // R3
  row_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc && blank_i) |=> row_cnt == '0);

  // R5
  col_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc && vsync_i) |=> col_cnt == '0);

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> $stable(row_cnt) && $stable(col_cnt));

  // R9
  half_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> half_col != $past(half_col));

  // R7
  one_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({row_we, col_we}));

  // R6
  gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (row_we || col_we) |-> buf_en);

endmodule

bind vmap_counter vmap_counter_chk #(.RW(ROW_AW), .CW(COL_AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .acc      (host_acc),
  .blank_i  (blank_i),
  .vsync_i  (vsync_i),
  .row_cnt  (row_cnt),
  .col_cnt  (col_cnt),
  .half_col (half_col),
  .buf_en   (map_buf_en_o),
  .row_we   (row_map_we_o),
  .col_we   (col_map_we_o)
);

// File: tb/vmap_counter_test.sv
module vmap_counter_test;
  localparam int RA = 7, CA = 10, HA = 16, DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic blank = 0, vs = 0, sel = 0, cs = 0, wr = 0, rd = 0;
  logic [HA-1:0] haddr = '0;
  logic [DW-1:0] hdata = '0;
  logic [DW-1:0] row_q, col_q, wdata, vaddr;
  logic [RA-1:0] raddr;
  logic [CA-1:0] caddr;
  logic rwe, cwe, buf_en, vcol;

  logic [DW-1:0] row_mem [1<<RA];
  logic [DW-1:0] col_mem [1<<CA];

  int checks = 0, fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  vmap_counter #(.ROW_AW(RA), .COL_AW(CA), .HOST_AW(HA), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .blank_i(blank), .vsync_i(vs),
    .map_sel_i(sel), .cs_i(cs), .wr_i(wr), .gc_rd_i(rd),
    .host_addr_i(haddr), .host_data_i(hdata),
    .row_map_q_i(row_q), .col_map_q_i(col_q),
    .row_map_addr_o(raddr), .col_map_addr_o(caddr),
    .row_map_we_o(rwe), .col_map_we_o(cwe), .map_wdata_o(wdata),
    .map_buf_en_o(buf_en), .vaddr_o(vaddr), .vaddr_col_o(vcol));

  assign row_q = row_mem[raddr];
  assign col_q = col_mem[caddr];

  always @(posedge clk) begin
    if (rwe) row_mem[raddr] <= wdata;
    if (cwe) col_mem[caddr] <= wdata;
  end

  typedef struct {
    logic [DW-1:0] va;
    logic vc;
    logic [RA-1:0] ra;
    logic [CA-1:0] ca;
    logic rwe, cwe, be;
    logic [DW-1:0] wd;
    bit rst, acc, pacc, blk, vs;
  } exp_t;

  exp_t sb[$];

  logic [RA-1:0] m_row;
  logic [CA-1:0] m_col;
  logic [DW-1:0] m_cr, m_cc;
  bit m_bq, m_half, m_pacc;

  always @(posedge clk) begin
    exp_t e;
    bit w, a;
    w = sel & cs & wr;
    a = w | (sel & rd);
    e.rst = !rst_n;
    if (!rst_n) begin
      m_row = '0; m_col = '0; m_cr = '0; m_cc = '0;
      m_bq = 0; m_half = 0; m_pacc = 0;
    end else begin
      if (m_half && !a) begin
        m_cr = row_mem[m_row];
        m_cc = col_mem[m_col];
      end
      m_half = !m_half;
      if (!a) begin
        if (blank) m_row = '0; else m_row = m_row + 1'b1;
        if (vs) m_col = '0;
        else if (blank && !m_bq) m_col = m_col + 1'b1;
      end
      m_bq = blank;
    end
    e.va   = m_half ? m_cc : m_cr;
    e.vc   = m_half;
    e.ra   = a ? haddr[RA-1:0] : m_row;
    e.ca   = a ? haddr[CA-1:0] : m_col;
    e.rwe  = w & !haddr[HA-1];
    e.cwe  = w & haddr[HA-1];
    e.be   = a;
    e.wd   = hdata;
    e.acc  = a;
    e.pacc = m_pacc;
    e.blk  = blank;
    e.vs   = vs;
    m_pacc = a;
    sb.push_back(e);
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  always @(posedge clk) begin
    exp_t e;
    #1;
    if (sb.size() > 0) begin
      e = sb.pop_front();
      if (e.rst) begin
        chk("R1 row address", 32'(raddr), 32'(e.ra));
        chk("R1 column address", 32'(caddr), 32'(e.ca));
        chk("R1 vaddr", 32'(vaddr), 32'(e.va));
        chk("R1 half select", 32'(vcol), 32'(e.vc));
      end else begin
        chk(e.acc ? "R6 row address" : e.pacc ? "R8 row hold" :
            e.blk ? "R3 row clear" : "R2 row step", 32'(raddr), 32'(e.ra));
        chk(e.acc ? "R6 column address" : e.pacc ? "R8 column hold" :
            e.vs ? "R5 column clear" : "R4 column step", 32'(caddr), 32'(e.ca));
        chk("R7 row we", 32'(rwe), 32'(e.rwe));
        chk("R7 column we", 32'(cwe), 32'(e.cwe));
        chk("R7 write data", 32'(wdata), 32'(e.wd));
        chk("R6 buffer gate", 32'(buf_en), 32'(e.be));
        chk("R9 half select", 32'(vcol), 32'(e.vc));
        chk(e.pacc ? "R10 vaddr hold" : "R9 vaddr", 32'(vaddr), 32'(e.va));
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic blank_pulse(int hi, int lo);
    @(negedge clk) blank = 1;
    idle(hi);
    blank = 0;
    idle(lo);
  endtask

  task automatic host_write(logic [HA-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    sel = 1; cs = 1; wr = 1; haddr = a; hdata = d;
    @(negedge clk);
    sel = 0; cs = 0; wr = 0;
  endtask

  task automatic gc_read(logic [HA-1:0] a, int n);
    @(negedge clk);
    sel = 1; rd = 1; haddr = a;
    idle(n);
    sel = 0; rd = 0;
  endtask

  initial begin
    for (int i = 0; i < (1 << RA); i++) row_mem[i] = DW'(i * 3 + 1);
    for (int i = 0; i < (1 << CA); i++) col_mem[i] = DW'(i ^ (i >> 2) ^ 8'hA5);
    idle(3);
    rst_n = 1;
    // R2: long run without blanking wraps the row index
    idle(140);
    // R3, R4: blanking pulses of several lengths
    for (int i = 0; i < 10; i++) blank_pulse(1 + (i % 3), 4 + i);
    // R5: vertical sync alone, then together with a blanking rise
    @(negedge clk) vs = 1;
    @(negedge clk) vs = 0;
    idle(5);
    blank_pulse(2, 3);
    @(negedge clk) begin vs = 1; blank = 1; end
    @(negedge clk) begin vs = 0; blank = 0; end
    idle(6);
    // R6, R7: host writes to both RAMs
    host_write(16'h0002, 8'h3C);
    host_write(16'h8003, 8'hC3);
    host_write(16'h0005, 8'h11);
    idle(3);
    // R8, R10: blanking and sync during a long access are ignored
    @(negedge clk) begin sel = 1; cs = 1; wr = 1; haddr = 16'h8001; hdata = 8'h77; blank = 1; end
    @(negedge clk) vs = 1;
    @(negedge clk) begin vs = 0; wr = 0; cs = 0; end
    @(negedge clk) begin sel = 0; blank = 0; end
    idle(4);
    // R6: controller reads, odd and even lengths
    gc_read(16'h0007, 3);
    idle(2);
    gc_read(16'h8004, 2);
    idle(4);
    // R4: column wrap through many short blanking pulses
    for (int i = 0; i < 1030; i++) blank_pulse(1, 1);
    idle(10);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule